// File: doc/BRIEF.md
# Fault-Injection Timing Supervisor

This block is the sequencing core of a test supervisor that places exactly one fault injection into a target board per run. A host asks for a run by pulsing a reset request. The supervisor then clears its own state and holds the target in reset for a fixed number of clocks. It then waits for the host to supply the injection point, which has two parts: a count of end-of-phase pulses from the target, and a delay in microseconds that starts once that count is reached.

Once the injection point has been accepted, the supervisor raises a freeze line so that the target's watchdogs stay quiet while the target sets itself up. The first pulse from the released target drops freeze. Each later pulse is counted. When the programmed count is met, a microsecond timer runs. The timer ticks from a clock prescaler. When it expires, freeze and the interrupt request rise together and launch the target's injection routine. Both lines drop on the target's next pulse, and the run is then marked finished. The current sequencing step is visible to the host as a 3-bit code.

Top module: `fi_supervisor`

## Requirements
- R1: After the synchronous reset `rst`, `state_o` reads 0 (idle) and `tgt_rst`, `freeze`, `irq` and `done` are all low. Target pulses and configuration strobes in the idle state change nothing.
- R2: A `host_rst_req` in any state takes priority over all other inputs. From the next cycle `state_o` reads 1 and `tgt_rst` is high for exactly RST_CYCLES cycles, with `freeze`, `irq` and `done` low. The state then moves to 2 (waiting for configuration).
- R3: In state 2, `cfg_valid` captures `cfg_pulses` and `cfg_usec`. From the next cycle `state_o` reads 3 and `freeze` is high. A `cfg_valid` in any other state is ignored and does not change the captured values.
- R4: In state 3, the first `tgt_pulse` drops `freeze` on the next cycle. That pulse is not counted. The state becomes 4 (counting), or 5 (timing) directly when the captured pulse count is 0.
- R5: In state 4, the pulse that brings the number of counted pulses up to the captured count moves the state to 5 on the next cycle. Earlier pulses leave it in 4.
- R6: The timer expires after the captured microsecond value times CLKS_PER_US clocks. If the pulse that starts timing is high in cycle k, `state_o` first reads 6 in cycle k + 2 + cfg_usec*CLKS_PER_US. A value of 0 gives k + 2.
- R7: On expiry, `freeze` and `irq` rise in the same cycle, and `state_o` reads 6 (injecting).
- R8: `irq` and `freeze` stay high until the next `tgt_pulse`. On the cycle after that pulse, both are low, `done` is high and `state_o` reads 7.
- R9: Target pulses that arrive while the timer runs are ignored and do not shift the injection cycle.
- R10: `done` stays high, and all other outputs stay low, until the next `host_rst_req`. Target pulses and configuration strobes in state 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_rst_req | input | 1 | Host request to start a new run (one-cycle pulse) |
| cfg_valid | input | 1 | Strobe that qualifies the injection point |
| cfg_pulses | input | PCNT_W | Number of target pulses to count before timing |
| cfg_usec | input | USEC_W | Delay in microseconds after the count is reached |
| tgt_pulse | input | 1 | End-of-phase pulse from the target (one cycle, synchronous) |
| tgt_rst | output | 1 | Reset to the target |
| freeze | output | 1 | Stalls the target's watchdogs |
| irq | output | 1 | External interrupt request that launches the injection |
| done | output | 1 | Run finished |
| state_o | output | 3 | Current step: 0 idle, 1 target reset, 2 wait config, 3 armed, 4 counting, 5 timing, 6 injecting, 7 done |

## Verification
The bench targets a pulse count of zero and a delay of zero. A design that mishandled the count of zero would sit forever in the counting step. One that mishandled the delay of zero would wait a full microsecond or wrap the timer. A pulse is sent in the middle of the timing window: a design that let it disturb the count or restart the prescaler would inject late. Reset requests are issued in the middle of counting, and configuration strobes are sent while armed or done. These catch designs that lose the reset priority or that overwrite the captured injection point.

// File: rtl/fi_pkg.sv
package fi_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_TRST   = 3'd1,
        ST_WCFG   = 3'd2,
        ST_ARMED  = 3'd3,
        ST_COUNT  = 3'd4,
        ST_TIMING = 3'd5,
        ST_INJECT = 3'd6,
        ST_DONE   = 3'd7
    } fi_state_e;

    function automatic logic holds_freeze(fi_state_e s);
        return (s == ST_ARMED) || (s == ST_INJECT);
    endfunction

endpackage

// File: rtl/fi_prescaler.sv
module fi_prescaler #(
    parameter int DIV = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = en && (cnt == CW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || !en)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    generate
        if (DIV > 1) begin : g_sparse
            assert_tick_sparse_R6: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/fi_pulse_counter.sv
module fi_pulse_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] target,
    output logic         hit
);
    logic [W-1:0] cnt;
    logic [W:0]   nxt;

    assign nxt = {1'b0, cnt} + 1'b1;
    assign hit = inc && (nxt == {1'b0, target});

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (inc)
            cnt <= nxt[W-1:0];
    end
endmodule

// File: rtl/fi_us_timer.sv
module fi_us_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] val,
    input  logic         tick,
    output logic         zero
);
    logic [W-1:0] t;

    assign zero = (t == '0);

    always_ff @(posedge clk) begin
        if (rst)
            t <= '0;
        else if (load)
            t <= val;
        else if (tick && !zero)
            t <= t - 1'b1;
    end
endmodule

// File: rtl/fi_ctrl.sv
module fi_ctrl
    import fi_pkg::*;
#(
    parameter int RST_CYCLES = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      host_rst_req,
    input  logic      cfg_valid,
    input  logic      tgt_pulse,
    input  logic      n_zero,
    input  logic      cnt_hit,
    input  logic      tmr_zero,
    output fi_state_e state_q,
    output logic      cfg_take,
    output logic      tmr_load
);
    localparam int RW = $clog2(RST_CYCLES + 1);

    fi_state_e     nxt;
    logic [RW-1:0] rcnt;
    logic          rst_last;

    assign rst_last = (rcnt == RW'(RST_CYCLES - 1));
    assign cfg_take = !host_rst_req && (state_q == ST_WCFG) && cfg_valid;
    assign tmr_load = !host_rst_req &&
                      (((state_q == ST_ARMED) && tgt_pulse && n_zero) ||
                       ((state_q == ST_COUNT) && cnt_hit));

    always_comb begin
        nxt = state_q;
        if (host_rst_req) begin
            nxt = ST_TRST;
        end else begin
            case (state_q)
                ST_TRST:   if (rst_last) nxt = ST_WCFG;
                ST_WCFG:   if (cfg_valid) nxt = ST_ARMED;
                ST_ARMED:  if (tgt_pulse) nxt = n_zero ? ST_TIMING : ST_COUNT;
                ST_COUNT:  if (cnt_hit) nxt = ST_TIMING;
                ST_TIMING: if (tmr_zero) nxt = ST_INJECT;
                ST_INJECT: if (tgt_pulse) nxt = ST_DONE;
                default:   nxt = state_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            rcnt    <= '0;
        end else begin
            state_q <= nxt;
            if (state_q != ST_TRST || host_rst_req)
                rcnt <= '0;
            else if (!rst_last)
                rcnt <= rcnt + 1'b1;
        end
    end

    assert_trst_entry_R2: assert property (@(posedge clk) disable iff (rst)
        host_rst_req |=> (state_q == ST_TRST));

    assert_trst_exit_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_TRST && rst_last && !host_rst_req) |=> (state_q == ST_WCFG));
endmodule

// File: rtl/fi_supervisor.sv
module fi_supervisor
    import fi_pkg::*;
#(
    parameter int CLKS_PER_US = 100,
    parameter int RST_CYCLES  = 16,
    parameter int PCNT_W      = 16,
    parameter int USEC_W      = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_rst_req,
    input  logic              cfg_valid,
    input  logic [PCNT_W-1:0] cfg_pulses,
    input  logic [USEC_W-1:0] cfg_usec,
    input  logic              tgt_pulse,
    output logic              tgt_rst,
    output logic              freeze,
    output logic              irq,
    output logic              done,
    output logic [2:0]        state_o
);
    fi_state_e         state;
    logic              cfg_take, tmr_load, cnt_hit, tmr_zero, us_tick;
    logic [PCNT_W-1:0] n_q;
    logic [USEC_W-1:0] u_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            n_q <= '0;
            u_q <= '0;
        end else if (cfg_take) begin
            n_q <= cfg_pulses;
            u_q <= cfg_usec;
        end
    end

    fi_ctrl #(.RST_CYCLES(RST_CYCLES)) u_ctrl (
        .clk(clk), .rst(rst), .host_rst_req(host_rst_req), .cfg_valid(cfg_valid),
        .tgt_pulse(tgt_pulse), .n_zero(n_q == '0), .cnt_hit(cnt_hit),
        .tmr_zero(tmr_zero), .state_q(state), .cfg_take(cfg_take), .tmr_load(tmr_load)
    );

    fi_pulse_counter #(.W(PCNT_W)) u_pcnt (
        .clk(clk), .rst(rst), .clr(state != ST_COUNT),
        .inc(tgt_pulse && state == ST_COUNT), .target(n_q), .hit(cnt_hit)
    );

    fi_prescaler #(.DIV(CLKS_PER_US)) u_presc (
        .clk(clk), .rst(rst), .en(state == ST_TIMING), .tick(us_tick)
    );

    fi_us_timer #(.W(USEC_W)) u_tmr (
        .clk(clk), .rst(rst), .load(tmr_load), .val(u_q), .tick(us_tick), .zero(tmr_zero)
    );

    assign tgt_rst = (state == ST_TRST);
    assign freeze  = holds_freeze(state);
    assign irq     = (state == ST_INJECT);
    assign done    = (state == ST_DONE);
    assign state_o = state;

    assert_cfg_stable_R3: assert property (@(posedge clk) disable iff (rst)
        (state != ST_WCFG) |=> ($stable(n_q) && $stable(u_q)));

    assert_inject_on_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TIMING && tmr_zero && !host_rst_req) |=> (irq && freeze));

    assert_irq_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (irq && !tgt_pulse && !host_rst_req) |=> irq);

    assert_irq_release_R8: assert property (@(posedge clk) disable iff (rst)
        (irq && tgt_pulse && !host_rst_req) |=> (!irq && !freeze && done));

    assert_done_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (done && !host_rst_req) |=> done);
endmodule

// File: tb/fi_supervisor_bench.sv
module fi_supervisor_bench;
    localparam int C  = 4;
    localparam int RC = 3;
    localparam int PW = 8;
    localparam int UW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_rst_req = 1'b0, cfg_valid = 1'b0, tgt_pulse = 1'b0;
    logic [PW-1:0] cfg_pulses = '0;
    logic [UW-1:0] cfg_usec = '0;
    logic tgt_rst, freeze, irq, done;
    logic [2:0] state_o;

    int errors = 0, checks = 0, cyc = 0, mark = 0;
    bit started = 0;

    always #5 clk = ~clk;

    fi_supervisor #(.CLKS_PER_US(C), .RST_CYCLES(RC), .PCNT_W(PW), .USEC_W(UW)) u_fi_supervisor (
        .clk(clk), .rst(rst), .host_rst_req(host_rst_req), .cfg_valid(cfg_valid),
        .cfg_pulses(cfg_pulses), .cfg_usec(cfg_usec), .tgt_pulse(tgt_pulse),
        .tgt_rst(tgt_rst), .freeze(freeze), .irq(irq), .done(done), .state_o(state_o)
    );

    // behavioural reference: step code plus remaining counts
    int m_st = 0, m_rc = 0, m_cnt = 0, m_wait = 0, m_n = 0, m_u = 0;

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_st = 0;
        end else if (host_rst_req) begin
            m_st = 1; m_rc = 0;
        end else begin
            case (m_st)
                1: begin m_rc++; if (m_rc == RC) m_st = 2; end
                2: if (cfg_valid) begin m_n = int'(cfg_pulses); m_u = int'(cfg_usec); m_st = 3; end
                3: if (tgt_pulse) begin
                       if (m_n == 0) begin m_st = 5; m_wait = m_u * C; end
                       else begin m_st = 4; m_cnt = 0; end
                   end
                4: if (tgt_pulse) begin
                       m_cnt++;
                       if (m_cnt == m_n) begin m_st = 5; m_wait = m_u * C; end
                   end
                5: if (m_wait == 0) m_st = 6; else m_wait--;
                6: if (tgt_pulse) m_st = 7;
                default: ;
            endcase
        end
        if (cyc > 50000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, 50000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic string req_of(int s);
        case (s)
            0: return "R1";  1: return "R2";  2: return "R3";  3: return "R4";
            4: return "R5";  5: return "R6";  6: return "R7";  default: return "R10";
        endcase
    endfunction

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (started) begin
            int act, exp;
            act = {state_o, tgt_rst, freeze, irq, done};
            exp = (m_st << 4) | ((m_st == 1) << 3) | ((m_st == 3 || m_st == 6) << 2) |
                  ((m_st == 6) << 1) | (m_st == 7);
            chk(act == exp, req_of(m_st), "outputs {state,rst,frz,irq,done}", act, exp);
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(bit rec);
        @(negedge clk);
        tgt_pulse = 1'b1;
        if (rec) mark = cyc;
        @(negedge clk);
        tgt_pulse = 1'b0;
    endtask

    task automatic host_req();
        @(negedge clk); host_rst_req = 1'b1;
        @(negedge clk); host_rst_req = 1'b0;
    endtask

    task automatic cfg(int n, int u);
        @(negedge clk);
        cfg_valid = 1'b1; cfg_pulses = PW'(n); cfg_usec = UW'(u);
        @(negedge clk);
        cfg_valid = 1'b0;
    endtask

    task automatic wait_st(int s, string req);
        int g = 0;
        while (int'(state_o) != s && g < 1000) begin @(negedge clk); g++; end
        chk(int'(state_o) == s, req, "reached state", int'(state_o), s);
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        started = 1;
        step(1);
        // R1: idle after reset, quiet outputs
        chk({tgt_rst, freeze, irq, done} == 4'b0 && state_o == 3'd0, "R1", "reset state",
            int'(state_o), 0);
        cfg(5, 5);
        pulse(0);
        step(1);
        chk(state_o == 3'd0, "R1", "idle ignores strobes", int'(state_o), 0);

        // run A: 3 pulses, 2 us, stray pulse during timing
        host_req();
        chk(tgt_rst == 1'b1 && state_o == 3'd1, "R2", "target reset asserted", int'(state_o), 1);
        wait_st(2, "R2");
        cfg(3, 2);
        chk(freeze == 1'b1, "R3", "freeze after config", int'(freeze), 1);
        cfg(9, 9); // ignored while armed (R3)
        pulse(0);
        chk(freeze == 1'b0 && state_o == 3'd4, "R4", "release pulse drops freeze", int'(state_o), 4);
        pulse(0); step(2); pulse(0);
        chk(state_o == 3'd4, "R5", "still counting", int'(state_o), 4);
        step(1);
        pulse(1);
        chk(state_o == 3'd5, "R5", "count reached", int'(state_o), 5);
        step(3);
        pulse(0); // R9: ignored during timing
        wait_st(6, "R6");
        chk(cyc - mark == 2 * C + 2, "R9", "injection cycle after stray pulse", cyc - mark, 2 * C + 2);
        chk(irq && freeze, "R7", "freeze and irq together", int'({freeze, irq}), 3);
        step(5);
        chk(irq == 1'b1, "R8", "irq held", int'(irq), 1);
        pulse(0);
        chk(done && !irq && !freeze && state_o == 3'd7, "R8", "release after pulse", int'(state_o), 7);
        pulse(0);
        cfg(1, 1);
        step(2);
        chk(done && state_o == 3'd7, "R10", "done holds", int'(state_o), 7);

        // run B: zero count, zero delay
        host_req();
        wait_st(2, "R2");
        cfg(0, 0);
        pulse(1);
        chk(state_o == 3'd5, "R4", "zero count skips counting", int'(state_o), 5);
        wait_st(6, "R6");
        chk(cyc - mark == 2, "R6", "zero delay latency", cyc - mark, 2);
        pulse(0);
        chk(done == 1'b1, "R8", "done after zero run", int'(done), 1);

        // run C: reset request in mid count, then 1 pulse, 1 us
        host_req();
        wait_st(2, "R2");
        cfg(4, 1);
        pulse(0); pulse(0);
        host_req();
        chk(state_o == 3'd1 && tgt_rst, "R2", "reset priority mid count", int'(state_o), 1);
        wait_st(2, "R2");
        cfg(1, 1);
        pulse(0);
        pulse(1);
        wait_st(6, "R6");
        chk(cyc - mark == C + 2, "R6", "one microsecond latency", cyc - mark, C + 2);
        pulse(0);
        step(2);
        chk(done == 1'b1, "R10", "final done", int'(done), 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule